// File: doc/BRIEF.md
# Vetoed Time-Stamp Clock and Counter

This block produces the tick that paces event time stamps and keeps the running 64-bit count of those ticks. In its normal mode it derives a tick from the system clock by dividing by four, so a 40 MHz system clock gives a 10 MHz stamp rate. While the busy (veto) input is high, ticks are suppressed. The divider keeps turning during a veto, so the tick phase is the same before and after it. A select input can swap the internal tick for an external stamp clock. That clock is brought into the system clock domain through two flops, and each rising edge then becomes a single-cycle enable.

Each counted tick also appears on a one-cycle output pulse. Other time-stamp modules can take that pulse and count exactly the same ticks. Software normally zeroes the count with the clear input, and a clear overrides any tick that arrives in the same cycle. The count is read through a small address port that returns one slice of the count per address, padded with zeros to a full data word.

Top module: `stamp_clock_counter`

## Requirements
- R1: After reset the count is zero and `tick_out` is low.
- R2: With `use_ext` low and `veto` low, a tick occurs on every fourth system clock cycle. Each tick adds one to the count and raises `tick_out` for exactly one cycle.
- R3: While `veto` is high, no tick is counted and `tick_out` stays low, whichever source is selected.
- R4: The divide-by-4 phase keeps running through a veto. After a veto that hides one tick, the next tick comes 8 cycles after the last tick before the veto.
- R5: With `use_ext` high, each rising edge of `ext_clk` adds exactly one to the count, two to three cycles after the edge, and the internal divider adds nothing. This holds for an `ext_clk` that stays high and low for at least two system cycles each.
- R6: When `clear` is high at a clock edge, the count is zero after that edge, even if a tick falls in the same cycle.
- R7: The count increments modulo 2^CNT_W, so it wraps from all ones to zero.
- R8: `rd_addr` values 1 to CNT_W/SLICE_W return count bits [16k-1:16(k-1)] for address k in the low bits of `rd_data`, with all upper bits of `rd_data` zero. Address 1 is the lowest slice. Any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (40 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| veto | input | 1 | Busy: suppresses stamp ticks while high |
| use_ext | input | 1 | 1 selects the external stamp clock, 0 the internal divide-by-4 tick |
| ext_clk | input | 1 | External stamp clock, asynchronous to `clk` |
| clear | input | 1 | Synchronous clear of the count |
| rd_addr | input | ADDR_W (4) | Slice address for readback |
| rd_data | output | WORD_W (24) | Selected slice, zero padded |
| tick_out | output | 1 | One-cycle pulse per counted tick, for distribution |

## Verification
The bench puts a clear on exactly the cycle of a tick. A design that lets the tick win then reads back one instead of zero. It times a veto that hides one tick and measures the gap to the next tick, which shows whether the divider phase stalled or restarted during the veto. The external path is driven with slow edges, with and without a veto. A missing edge detector would count once per cycle while the level is high, and a missing mask would count through the veto. A narrow instance is run past all ones to check the wrap, and the address port is checked at its unused addresses, where a sloppy decoder would alias a slice.

// File: rtl/stamp_clock_counter.sv
module stamp_clock_counter #(
  parameter int CNT_W   = 64,
  parameter int SLICE_W = 16,
  parameter int WORD_W  = 24,
  parameter int ADDR_W  = 4,
  parameter int DIV     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              veto,
  input  logic              use_ext,
  input  logic              ext_clk,
  input  logic              clear,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              tick_out
);
  localparam int NSLICE = CNT_W / SLICE_W;
  localparam int PH_W   = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PH_W-1:0]  phase;
  logic [2:0]       ext_sh;
  logic [CNT_W-1:0] cnt;
  logic             int_tick, ext_rise, tick_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         phase <= '0;
    else if (phase == PH_W'(DIV - 1))   phase <= '0;
    else                                phase <= phase + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ext_sh <= '0;
    else        ext_sh <= {ext_sh[1:0], ext_clk};

  assign int_tick = (phase == PH_W'(DIV - 1));
  assign ext_rise = ext_sh[1] & ~ext_sh[2];
  assign tick_en  = (use_ext ? ext_rise : int_tick) & ~veto;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (tick_en) cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tick_out <= 1'b0;
    else        tick_out <= tick_en;

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NSLICE; i++)
      if (rd_addr == ADDR_W'(i + 1))
        rd_data[SLICE_W-1:0] = cnt[i*SLICE_W +: SLICE_W];
  end

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt == '0);
  assert_veto_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (veto && !clear) |=> (cnt == $past(cnt) && !tick_out));
  assert_step_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |=> !tick_out);
  assert_unused_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == '0 || int'(rd_addr) > NSLICE) |-> rd_data == '0);
endmodule

// File: tb/test_stamp_clock_counter.sv
module test_stamp_clock_counter;
  logic clk = 0, rst_n = 0, veto = 0, use_ext = 0, ext_clk = 0, clear = 0;
  logic [3:0] rd_addr = 0;
  logic [23:0] rd_data;
  logic tick_out;
  logic s_clear = 0;
  logic [3:0] s_addr = 0;
  logic [23:0] s_data;
  logic s_tick;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  stamp_clock_counter i_stamp_clock_counter (
    .clk(clk), .rst_n(rst_n), .veto(veto), .use_ext(use_ext), .ext_clk(ext_clk),
    .clear(clear), .rd_addr(rd_addr), .rd_data(rd_data), .tick_out(tick_out));

  stamp_clock_counter #(.CNT_W(8), .SLICE_W(4)) i_small (
    .clk(clk), .rst_n(rst_n), .veto(1'b0), .use_ext(1'b0), .ext_clk(1'b0),
    .clear(s_clear), .rd_addr(s_addr), .rd_data(s_data), .tick_out(s_tick));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_cnt(output logic [63:0] v);
    for (int k = 0; k < 4; k++) begin
      rd_addr = 4'(k + 1);
      #1;
      v[k*16 +: 16] = rd_data[15:0];
    end
    rd_addr = 0;
  endtask

  task automatic do_clear();
    clear = 1; step(1); clear = 0;
  endtask

  task automatic wait_tick();
    while (tick_out !== 1'b1) step(1);
  endtask

  task automatic t_reset();
    logic [63:0] v;
    read_cnt(v);
    chk("R1 count", v, 0);
    chk("R1 tick_out", tick_out, 0);
  endtask

  task automatic t_internal();
    logic [63:0] v;
    int gap;
    do_clear();
    read_cnt(v); chk("R6 clear", v, 0);
    step(40);
    read_cnt(v); chk("R2 ten ticks in 40 cycles", v, 10);
    wait_tick();
    step(1);
    chk("R2 pulse one cycle", tick_out, 0);
    gap = 1;
    while (tick_out !== 1'b1 && gap < 20) begin step(1); gap++; end
    chk("R2 tick spacing", gap, 4);
  endtask

  task automatic t_veto();
    logic [63:0] v;
    int seen = 0;
    do_clear();
    veto = 1;
    for (int i = 0; i < 40; i++) begin step(1); if (tick_out) seen++; end
    veto = 0;
    read_cnt(v);
    chk("R3 veto count", v, 0);
    chk("R3 veto tick_out", seen, 0);
  endtask

  task automatic t_phase();
    int n;
    wait_tick();
    veto = 1; step(6); veto = 0;
    n = 6;
    while (tick_out !== 1'b1 && n < 30) begin step(1); n++; end
    chk("R4 phase kept", n, 8);
  endtask

  task automatic t_clear_wins();
    logic [63:0] v;
    step(8);
    wait_tick();
    clear = 1; step(4);
    read_cnt(v);
    chk("R6 clear beats tick", v, 0);
    clear = 0;
  endtask

  task automatic t_ext();
    logic [63:0] v;
    use_ext = 1; ext_clk = 0; step(5);
    do_clear();
    for (int i = 0; i < 6; i++) begin
      ext_clk = 1; step(5); ext_clk = 0; step(5);
    end
    step(5);
    read_cnt(v); chk("R5 ext edges", v, 6);
    veto = 1;
    for (int i = 0; i < 3; i++) begin
      ext_clk = 1; step(3); ext_clk = 0; step(3);
    end
    step(5); veto = 0; step(4);
    read_cnt(v); chk("R3 ext vetoed", v, 6);
    use_ext = 0;
  endtask

  task automatic t_read();
    logic [63:0] v;
    do_clear();
    step(4 * 'h123);
    rd_addr = 1; #1; chk("R8 addr1", rd_data, 24'h000123);
    rd_addr = 2; #1; chk("R8 addr2", rd_data, 0);
    rd_addr = 4; #1; chk("R8 addr4", rd_data, 0);
    rd_addr = 0; #1; chk("R8 addr0", rd_data, 0);
    rd_addr = 5; #1; chk("R8 addr5", rd_data, 0);
    rd_addr = 15; #1; chk("R8 addr15", rd_data, 0);
    rd_addr = 0;
  endtask

  task automatic t_wrap();
    s_clear = 1; step(1); s_clear = 0;
    step(4 * (256 + 'h2B));
    s_addr = 1; #1; chk("R7 wrap low slice", s_data, 24'h00000B);
    s_addr = 2; #1; chk("R7 wrap high slice", s_data, 24'h000002);
    s_addr = 3; #1; chk("R8 small unused", s_data, 0);
    s_addr = 0;
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1;
    step(2);
    t_internal();
    t_veto();
    t_phase();
    t_clear_wins();
    t_ext();
    t_read();
    t_wrap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule